// File: doc/BRIEF.md
# Protected Segment Descriptor Builder

This block prepares the FS and GS segment descriptors that a thread uses once it has entered a protected memory region. For each of the two segments it adds a per-thread offset to the region base address to form the new base. It then checks that the resulting segment is acceptable. Finally it assembles a complete descriptor, made of base, limit and attribute fields, ready to be loaded by the surrounding control logic.

The acceptance rule depends on the operating mode. In 32-bit mode the segment's top address must lie inside the current data segment. A segment whose top wraps past the end of the 32-bit space is allowed only when the data segment is flat over the whole 4 GB. In 64-bit mode no limit is checked, and each new base must be a canonical address instead. In both modes each offset must be 4 KB aligned.

The results appear one clock after a request. They stay unchanged until the next request arrives.

Top module: `seg_desc_builder`

## Requirements
- R1: One cycle after a request, each base output equals thread offset + region base. In 64-bit mode the full 64-bit sum is used. In 32-bit mode the low 32 bits of the sum are used, zero-extended.
- R2: A segment whose offset has any of bits 11:0 set is flagged as failing, in either mode.
- R3: In 32-bit mode, let top = base + thread limit, computed modulo 2^32. If top is lower than base (wrap-around), the segment fails unless the data-segment limit is 0xFFFFFFFF.
- R4: In 32-bit mode without wrap-around, the segment fails exactly when top is greater than the data-segment limit. A top equal to that limit is accepted.
- R5: In 64-bit mode the segment fails when bits 63:47 of its base are not all equal. The thread limit and the data-segment limit have no effect on the result.
- R6: Every attribute output has the layout [3:0] type, [4] W, [5] S, [7:6] DPL, [8] P, [9] AVL, [10] L, [11] B, [12] G, [13] unusable, [29:14] selector. The fixed values are type 0001b, S=P=B=G=1, unusable=0 and selector 0x000B.
- R7: In each attribute output, the W, DPL, AVL and L fields are copied from the data-segment inputs. Each limit output equals its segment's thread limit.
- R8: fault_mask bit 0 reports FS and bit 1 reports GS. The two segments are judged independently, and fault is the OR of the two mask bits.
- R9: rsp_valid is high for exactly the cycle after each request cycle. All result outputs hold their values while no request is made. Reset clears rsp_valid, fault and fault_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| mode64 | input | 1 | 1 selects 64-bit rules, 0 selects 32-bit rules |
| region_base | input | 64 | Base address of the protected region |
| fs_ofs | input | 64 | Thread FS offset |
| gs_ofs | input | 64 | Thread GS offset |
| fs_lim | input | 32 | Thread FS limit |
| gs_lim | input | 32 | Thread GS limit |
| ds_limit | input | 32 | Data-segment limit |
| ds_w | input | 1 | Data-segment writable attribute |
| ds_dpl | input | 2 | Data-segment privilege level |
| ds_avl | input | 1 | Data-segment available bit |
| ds_l | input | 1 | Data-segment long-mode bit |
| rsp_valid | output | 1 | Results valid strobe |
| fs_base | output | 64 | Built FS base |
| fs_limit | output | 32 | Built FS limit |
| fs_attr | output | 30 | Built FS attributes and selector |
| gs_base | output | 64 | Built GS base |
| gs_limit | output | 32 | Built GS limit |
| gs_attr | output | 30 | Built GS attributes and selector |
| fault | output | 1 | Either segment failed |
| fault_mask | output | 2 | Per-segment failure, bit 0 FS, bit 1 GS |

## Verification
Some properties are checked on every cycle. These cover the response timing, results holding between requests, the limit outputs following the request, and a misaligned offset always producing its mask bit. The other rules depend on specific address values, and only the bench scenarios can show them. These are the 32-bit containment rule at its exact boundary, wrap-around under flat and non-flat data segments, and canonical checks on positive and negative halves. They also include independent FS and GS verdicts, and a 64-bit limit that is ignored.

// File: rtl/seg_desc_builder.sv
module seg_desc_builder #(
  parameter int AW = 64,
  parameter int VA_W = 48,
  parameter int LW = 32,
  parameter int SEL_W = 16,
  parameter logic [SEL_W-1:0] SEL_VAL = 'h0B
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                mode64,
  input  logic [AW-1:0]       region_base,
  input  logic [AW-1:0]       fs_ofs,
  input  logic [AW-1:0]       gs_ofs,
  input  logic [LW-1:0]       fs_lim,
  input  logic [LW-1:0]       gs_lim,
  input  logic [LW-1:0]       ds_limit,
  input  logic                ds_w,
  input  logic [1:0]          ds_dpl,
  input  logic                ds_avl,
  input  logic                ds_l,
  output logic                rsp_valid,
  output logic [AW-1:0]       fs_base,
  output logic [LW-1:0]       fs_limit,
  output logic [SEL_W+13:0]   fs_attr,
  output logic [AW-1:0]       gs_base,
  output logic [LW-1:0]       gs_limit,
  output logic [SEL_W+13:0]   gs_attr,
  output logic                fault,
  output logic [1:0]          fault_mask
);
  localparam int ATTR_W = SEL_W + 14;
  localparam int PG = 12;
  localparam int NSEG = 2;

  logic [NSEG-1:0][AW-1:0] ofs_v;
  logic [NSEG-1:0][LW-1:0] lim_v;
  logic [NSEG-1:0][AW-1:0] base_n;
  logic [NSEG-1:0]         bad_n;
  logic [ATTR_W-1:0]       attr_n;
  logic                    flat_ds;

  assign ofs_v   = {gs_ofs, fs_ofs};
  assign lim_v   = {gs_lim, fs_lim};
  assign flat_ds = &ds_limit;

  assign attr_n = {SEL_VAL, 1'b0, 1'b1, 1'b1, ds_l, ds_avl, 1'b1, ds_dpl, 1'b1, ds_w, 4'b0001};

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [AW-1:0]      sum_w;
    logic [LW-1:0]      base32;
    logic [LW-1:0]      top32;
    logic [AW-VA_W:0]   hi;
    logic               canon, wrap, misal, bad32;

    assign sum_w  = ofs_v[g] + region_base;
    assign base32 = sum_w[LW-1:0];
    assign top32  = base32 + lim_v[g];
    assign wrap   = top32 < base32;
    assign hi     = sum_w[AW-1:VA_W-1];
    assign canon  = (&hi) | ~(|hi);
    assign misal  = |ofs_v[g][PG-1:0];
    assign bad32  = wrap ? ~flat_ds : (top32 > ds_limit);
    assign bad_n[g]  = misal | (mode64 ? ~canon : bad32);
    assign base_n[g] = mode64 ? sum_w : {{(AW-LW){1'b0}}, base32};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      fault_mask <= '0;
      fs_base    <= '0;
      gs_base    <= '0;
      fs_limit   <= '0;
      gs_limit   <= '0;
      fs_attr    <= '0;
      gs_attr    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        fault_mask <= bad_n;
        fs_base    <= base_n[0];
        gs_base    <= base_n[1];
        fs_limit   <= fs_lim;
        gs_limit   <= gs_lim;
        fs_attr    <= attr_n;
        gs_attr    <= attr_n;
      end
    end
  end

  assign fault = |fault_mask;

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(fs_base) && $stable(gs_base) && $stable(fault_mask)));
  // R2
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (fs_ofs[PG-1:0] != '0)) |=> fault_mask[0]);
  // R2
  gs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (gs_ofs[PG-1:0] != '0)) |=> fault_mask[1]);
  // R7
  limit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (fs_limit == $past(fs_lim) && gs_limit == $past(gs_lim)));
endmodule

// File: tb/test_seg_desc_builder.sv
module test_seg_desc_builder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic mode64 = 1'b0;
  logic [63:0] region_base = '0, fs_ofs = '0, gs_ofs = '0;
  logic [31:0] fs_lim = '0, gs_lim = '0, ds_limit = '0;
  logic ds_w = 1'b0, ds_avl = 1'b0, ds_l = 1'b0;
  logic [1:0] ds_dpl = '0;
  logic rsp_valid, fault;
  logic [63:0] fs_base, gs_base;
  logic [31:0] fs_limit, gs_limit;
  logic [29:0] fs_attr, gs_attr;
  logic [1:0] fault_mask;

  int n_chk = 0, n_bad = 0;

  typedef struct {
    logic [63:0] fb, gb;
    logic [31:0] fl, gl;
    logic [29:0] at;
    logic [1:0]  mask;
  } exp_t;
  exp_t sb[$];
  exp_t last;

  always #4 clk = ~clk;

  seg_desc_builder i_seg_desc_builder (
    .clk, .rst_n, .req_valid, .mode64, .region_base, .fs_ofs, .gs_ofs,
    .fs_lim, .gs_lim, .ds_limit, .ds_w, .ds_dpl, .ds_avl, .ds_l,
    .rsp_valid, .fs_base, .fs_limit, .fs_attr, .gs_base, .gs_limit,
    .gs_attr, .fault, .fault_mask);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic seg_bad(logic m, logic [63:0] rb, logic [63:0] o,
                                   logic [31:0] lim, logic [31:0] dsl);
    logic [63:0] s;
    logic [32:0] b, t;
    if (o[11:0] != 12'h0) return 1'b1;
    s = o + rb;
    if (m) return !((s[63:47] == '0) || (s[63:47] == '1));
    b = {1'b0, s[31:0]};
    t = b + {1'b0, lim};
    if (t[32]) return dsl != 32'hFFFF_FFFF;
    return t[31:0] > dsl;
  endfunction

  function automatic logic [63:0] exp_base(logic m, logic [63:0] rb, logic [63:0] o);
    logic [63:0] s;
    s = o + rb;
    return m ? s : {32'h0, s[31:0]};
  endfunction

  task automatic send(logic m, logic [63:0] rb, logic [63:0] fo, logic [63:0] go,
                      logic [31:0] fl, logic [31:0] gl, logic [31:0] dsl,
                      logic w, logic [1:0] dpl, logic avl, logic l);
    exp_t e;
    e.fb = exp_base(m, rb, fo);
    e.gb = exp_base(m, rb, go);
    e.fl = fl;
    e.gl = gl;
    e.at = '0;
    e.at[3:0] = 4'b0001; e.at[4] = w; e.at[5] = 1'b1; e.at[7:6] = dpl;
    e.at[8] = 1'b1; e.at[9] = avl; e.at[10] = l; e.at[11] = 1'b1;
    e.at[12] = 1'b1; e.at[13] = 1'b0; e.at[29:14] = 16'h000B;
    e.mask = {seg_bad(m, rb, go, gl, dsl), seg_bad(m, rb, fo, fl, dsl)};
    sb.push_back(e);
    last = e;
    @(negedge clk);
    req_valid = 1'b1; mode64 = m; region_base = rb; fs_ofs = fo; gs_ofs = go;
    fs_lim = fl; gs_lim = gl; ds_limit = dsl; ds_w = w; ds_dpl = dpl;
    ds_avl = avl; ds_l = l;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R1 fs_base", fs_base, e.fb);
        check("R1 gs_base", gs_base, e.gb);
        check("R2-R5 fs verdict", 64'(fault_mask[0]), 64'(e.mask[0]));
        check("R2-R5 gs verdict", 64'(fault_mask[1]), 64'(e.mask[1]));
        check("R8 fault", 64'(fault), 64'(|e.mask));
        check("R7 fs_limit", 64'(fs_limit), 64'(e.fl));
        check("R7 gs_limit", 64'(gs_limit), 64'(e.gl));
        check("R6 R7 fs_attr", 64'(fs_attr), 64'(e.at));
        check("R6 R7 gs_attr", 64'(gs_attr), 64'(e.at));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset rsp_valid", 64'(rsp_valid), 64'h0);
    check("R9 reset fault", 64'(fault), 64'h0);
    check("R9 reset mask", 64'(fault_mask), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: FS fits, GS fits
    send(0, 64'h1_0000, 64'h2000, 64'h3000, 32'hFFF, 32'h1FFF, 32'hFFFF_FFFF, 1, 2'd3, 0, 0);
    // R4: FS top equals limit (ok), GS top above limit
    send(0, 64'h1_0000, 64'h2000, 64'h3000, 32'hFFF, 32'h1000, 32'h0001_2FFF, 0, 2'd1, 1, 1);
    // R2: FS misaligned only
    send(0, 64'h1_0000, 64'h2010, 64'h3000, 32'h10, 32'h10, 32'hFFFF_FFFF, 1, 2'd0, 0, 1);
    // R3: wrap with flat data segment
    send(0, 64'hFFFF_0000, 64'h8000, 64'h0, 32'h1_0000, 32'h100, 32'hFFFF_FFFF, 1, 2'd2, 1, 0);
    // R3: wrap with non-flat data segment
    send(0, 64'hFFFF_0000, 64'h8000, 64'h0, 32'h1_0000, 32'h100, 32'hFFFF_FFFE, 0, 2'd2, 0, 0);
    // R1: 32-bit base truncation of a large region base
    send(0, 64'h1234_5678_0000_0000, 64'h1000, 64'h2000, 32'h0, 32'h0, 32'h0000_FFFF, 1, 2'd0, 0, 0);
    // R5: canonical positive half, tiny ds limit ignored
    send(1, 64'h0000_7FFF_0000_0000, 64'h1000, 64'h2000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 2'd3, 1, 1);
    // R5: GS lands non-canonical
    send(1, 64'h0000_7FFF_0000_0000, 64'h1000, 64'h1_0000_0000, 32'h0, 32'h0, 32'h0, 0, 2'd3, 0, 1);
    // R5: negative canonical half, FS non-canonical
    send(1, 64'hFFFF_8000_0000_0000, 64'hFFFF_0000_0000_0000, 64'h0, 32'h5, 32'h5, 32'h0, 1, 2'd1, 1, 0);
    // R2 in 64-bit mode, both misaligned
    send(1, 64'h0, 64'h800, 64'h1, 32'h0, 32'h0, 32'hFFFF_FFFF, 0, 2'd0, 0, 0);
    repeat (4) @(negedge clk);
    // R9 hold after idle cycles
    check("R9 hold rsp_valid", 64'(rsp_valid), 64'h0);
    check("R9 hold fs_base", fs_base, last.fb);
    check("R9 hold mask", 64'(fault_mask), 64'(last.mask));
    check("R9 queue drained", 64'(sb.size()), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule